// File: doc/BRIEF.md
# Trace packet emission sequencer

This block sits behind an instruction-trace front end. Whenever the core retires a far branch or takes a hardware interrupt, the front end offers one event. The event carries the operation type, the packet-enable state just before and just after the event, the context-enable state after it, a set of side-condition flags and three addresses: the branch target, the next sequential instruction address and the new page-table base. From these inputs the sequencer decides which trace packets the event calls for. It then hands them one at a time to a downstream encoder over a valid/ready stream, each packet with its address payload attached.

The packet set depends jointly on the enable transition, on whether context tracing stays on, and on the flags. A flow-update packet opens the sequence when an interrupt ends tracing. A page-table-base packet follows when the base register changed under the privileged-mode filter. A mode packet can come next, then one of three target packets, and a trace-stop packet closes the sequence. A small state bit records whether a mode packet has gone out since the last sync point, and an external sync pulse clears it. A new event is accepted only once the previous sequence has fully drained. Turning packets into bytes, compressing addresses and buffering are left to later stages.

Top module: `trace_pkt_seq`

## Requirements
- R1: `ev_ready` is high exactly when no packet of the previous event is still pending. An event is taken on `ev_valid && ev_ready`, and its first packet appears on the cycle after acceptance. An event that calls for no packet leaves `pkt_valid` low and `ev_ready` high.
- R2: While `pkt_valid` is high and `pkt_ready` is low, the packet kind and all payload outputs stay unchanged.
- R3: The packets of one event come out in this order, with each kind optional: flow update (kind 0), page-table base (kind 1), mode (kind 2), target packet (kind 3, 4 or 5), trace stop (kind 6). No kind repeats within an event.
- R4: A flow-update packet is emitted if and only if the event is a hardware interrupt (`ev_is_intr`=1) with enable before = 1 and enable after = 0. It carries `ev_next_ip` with the address-valid flag set.
- R5: A page-table-base packet is emitted if and only if context enable after = 1, base changed = 1 and privileged filter = 1. It carries `ev_new_base` with the address-valid flag set. Its `pkt_nonroot` output equals `ev_guest_vis`. Every other packet kind drives `pkt_nonroot` = 0.
- R6: The target packet follows the enable transition. Enable 1→1 gives a plain target (kind 3). Enable 0→1 gives tracing-enabled (kind 4). Both of these carry `ev_target`. Enable 1→0 gives tracing-disabled (kind 5), which carries `ev_target` with the address-valid flag set only when context enable after = 1, and otherwise has the address-valid flag low and address 0. Enable 0→0 gives no target packet.
- R7: A mode packet requires enable after = 1. With enable before = 1 it is emitted when `ev_mode_chg` = 1. With enable before = 0 it is emitted when `ev_mode_chg` = 1 or when no mode packet has been emitted since the last sync point. It carries no address.
- R8: The "mode sent" state is set when a mode packet is handed over. It is cleared by reset and by `sync_mark`. A `sync_mark` in the same cycle as an accepted event takes effect before that event's mode decision.
- R9: A trace-stop packet is emitted if and only if enable after = 0, context enable after = 1 and `ev_in_stop` = 1. It carries no address.
- R10: After reset, `pkt_valid` is 0, `ev_ready` is 1 and no mode packet counts as sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Sequencer idle, event can be taken |
| ev_is_intr | input | 1 | 1 = hardware interrupt, 0 = far branch |
| ev_en_before | input | 1 | Packet enable before the event |
| ev_en_after | input | 1 | Packet enable after the event |
| ev_ctx_after | input | 1 | Context enable after the event |
| ev_base_chg | input | 1 | Page-table base register was updated |
| ev_priv_filt | input | 1 | Privileged-mode trace filter set |
| ev_guest_vis | input | 1 | Destination is an unconcealed guest context |
| ev_in_stop | input | 1 | Target lies in a stop region |
| ev_mode_chg | input | 1 | Execution mode changed |
| ev_target | input | ADDR_W | Branch target address |
| ev_next_ip | input | ADDR_W | Next sequential instruction address |
| ev_new_base | input | ADDR_W | New page-table base value |
| sync_mark | input | 1 | Sync point: forget previous mode packets |
| pkt_valid | output | 1 | Packet available |
| pkt_ready | input | 1 | Consumer takes the packet |
| pkt_kind | output | 3 | Packet kind code (see R3) |
| pkt_addr | output | ADDR_W | Packet address payload |
| pkt_addr_vld | output | 1 | Address payload present |
| pkt_nonroot | output | 1 | Non-root flag of page-table-base packet |

## Verification
The bench walks every combination of operation, the three enable bits and the five flags. It mixes sync pulses into the sweep and stalls the consumer on a fixed pattern. A sequencer that got the mode-since-sync rule wrong would emit or drop the mode packet on enabling events after a sync or after an earlier mode packet. One that mishandled the disabled-target address would attach an address when context tracing ends. The interrupt-only flow update, the stop packet's dependence on context enable, and the ordering of the optional packets are each compared packet by packet. Under stalls a wrong hold would show up as a changed payload or a skipped packet.

// File: rtl/trace_pkt_pkg.sv
// Package: shared packet kind codes and slot order for the trace packet
// sequencer. Slot order is the emission order; kind codes are what the
// downstream encoder decodes.
package trace_pkt_pkg;
    typedef enum logic [2:0] {
        PK_FLOW    = 3'd0,
        PK_BASE    = 3'd1,
        PK_MODE    = 3'd2,
        PK_TGT     = 3'd3,
        PK_TGT_ON  = 3'd4,
        PK_TGT_OFF = 3'd5,
        PK_STOP    = 3'd6
    } pkt_kind_e;

    localparam int SLOTS     = 5;
    localparam int SLOT_FLOW = 0;
    localparam int SLOT_BASE = 1;
    localparam int SLOT_MODE = 2;
    localparam int SLOT_TGT  = 3;
    localparam int SLOT_STOP = 4;
endpackage

// File: rtl/trace_pkt_plan.sv
// Module: trace_pkt_plan
// Purely combinational decision of which packet slots an event needs and
// which target packet variant applies. Assumes mode_sent_eff already has
// any same-cycle sync applied.
module trace_pkt_plan
    import trace_pkt_pkg::*;
(
    input  logic             is_intr,
    input  logic             en_before,
    input  logic             en_after,
    input  logic             ctx_after,
    input  logic             base_chg,
    input  logic             priv_filt,
    input  logic             in_stop,
    input  logic             mode_chg,
    input  logic             mode_sent_eff,
    output logic [SLOTS-1:0] slot_mask,
    output logic [2:0]       tgt_kind,
    output logic             tgt_addr_vld
);
    // Slot selection per enable transition and side flags.
    always_comb begin
        slot_mask            = '0;
        slot_mask[SLOT_FLOW] = is_intr & en_before & ~en_after;
        slot_mask[SLOT_BASE] = ctx_after & base_chg & priv_filt;
        slot_mask[SLOT_MODE] = en_after & (en_before ? mode_chg : (mode_chg | ~mode_sent_eff));
        slot_mask[SLOT_TGT]  = en_before | en_after;
        slot_mask[SLOT_STOP] = ~en_after & ctx_after & in_stop;
    end

    // Target variant and whether it carries an address.
    always_comb begin
        if (en_before && en_after) begin
            tgt_kind = PK_TGT;
        end else if (en_after) begin
            tgt_kind = PK_TGT_ON;
        end else begin
            tgt_kind = PK_TGT_OFF;
        end
        tgt_addr_vld = en_after | ctx_after;
    end

    // R4: flow update never requested for a far branch.
    always_comb begin
        a_r4_flow_intr_only: assert (!(slot_mask[SLOT_FLOW] && !is_intr));
    end
endmodule

// File: rtl/trace_pkt_mode_track.sv
// Module: trace_pkt_mode_track
// Remembers whether a mode packet was handed over since the last sync
// point. A sync pulse wins over a same-cycle handover and is visible to
// the event decision in the same cycle.
module trace_pkt_mode_track (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mark,
    input  logic mode_ack,
    output logic mode_sent_eff
);
    logic mode_sent_q;

    // State register: set on mode handover, cleared by sync or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_sent_q <= 1'b0;
        end else if (sync_mark) begin
            mode_sent_q <= 1'b0;
        end else if (mode_ack) begin
            mode_sent_q <= 1'b1;
        end
    end

    // Value seen by this cycle's decision, sync applied first.
    assign mode_sent_eff = mode_sent_q & ~sync_mark;

    // R8: sync clears the state.
    a_r8_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mark |=> !mode_sent_q);
    // R8: handover without sync sets the state.
    a_r8_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ack && !sync_mark) |=> mode_sent_q);
endmodule

// File: rtl/trace_pkt_pick.sv
// Module: trace_pkt_pick
// Finds the lowest set bit of a pending slot mask (the next packet in
// emission order) as a one-hot vector and an index.
module trace_pkt_pick #(
    parameter int N  = 5,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic [N-1:0]  first,
    output logic [IW-1:0] idx
);
    // One-hot of the lowest pending slot.
    for (genvar g = 0; g < N; g++) begin : g_first
        if (g == 0) begin : g_lsb
            assign first[g] = mask[g];
        end else begin : g_upper
            assign first[g] = mask[g] & ~(|mask[g-1:0]);
        end
    end

    // Encode the one-hot position.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = IW'(i);
        end
    end

    // R3: never more than one slot selected.
    always_comb begin
        a_r3_single_slot: assert ($onehot0(first));
    end
endmodule

// File: rtl/trace_pkt_seq.sv
// Module: trace_pkt_seq (top)
// Takes one far-branch or interrupt event at a time, plans its packet
// slots, then emits them one by one in slot order over valid/ready.
// Assumes the consumer may stall arbitrarily; payloads are captured at
// event acceptance and held until the sequence drains.
module trace_pkt_seq
    import trace_pkt_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic              ev_is_intr,
    input  logic              ev_en_before,
    input  logic              ev_en_after,
    input  logic              ev_ctx_after,
    input  logic              ev_base_chg,
    input  logic              ev_priv_filt,
    input  logic              ev_guest_vis,
    input  logic              ev_in_stop,
    input  logic              ev_mode_chg,
    input  logic [ADDR_W-1:0] ev_target,
    input  logic [ADDR_W-1:0] ev_next_ip,
    input  logic [ADDR_W-1:0] ev_new_base,
    input  logic              sync_mark,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [2:0]        pkt_kind,
    output logic [ADDR_W-1:0] pkt_addr,
    output logic              pkt_addr_vld,
    output logic              pkt_nonroot
);
    localparam int IW = $clog2(SLOTS);

    logic [SLOTS-1:0]  plan_mask;
    logic [2:0]        plan_tgt_kind;
    logic              plan_tgt_av;
    logic              mode_sent_eff;
    logic [SLOTS-1:0]  pend_q;
    logic [SLOTS-1:0]  cur_first;
    logic [IW-1:0]     cur_idx;
    logic [ADDR_W-1:0] tgt_q, nip_q, base_q;
    logic [2:0]        tgt_kind_q;
    logic              tgt_av_q, nonroot_q;
    logic              take_ev, take_pkt, mode_ack;

    assign ev_ready  = ~(|pend_q);
    assign take_ev   = ev_valid & ev_ready;
    assign pkt_valid = |pend_q;
    assign take_pkt  = pkt_valid & pkt_ready;
    assign mode_ack  = take_pkt & cur_first[SLOT_MODE];

    trace_pkt_mode_track u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_mark    (sync_mark),
        .mode_ack     (mode_ack),
        .mode_sent_eff(mode_sent_eff)
    );

    trace_pkt_plan u_plan (
        .is_intr      (ev_is_intr),
        .en_before    (ev_en_before),
        .en_after     (ev_en_after),
        .ctx_after    (ev_ctx_after),
        .base_chg     (ev_base_chg),
        .priv_filt    (ev_priv_filt),
        .in_stop      (ev_in_stop),
        .mode_chg     (ev_mode_chg),
        .mode_sent_eff(mode_sent_eff),
        .slot_mask    (plan_mask),
        .tgt_kind     (plan_tgt_kind),
        .tgt_addr_vld (plan_tgt_av)
    );

    trace_pkt_pick #(.N(SLOTS), .IW(IW)) u_pick (
        .mask (pend_q),
        .first(cur_first),
        .idx  (cur_idx)
    );

    // Pending-slot register: load on event, retire one slot per handover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (take_ev) begin
            pend_q <= plan_mask;
        end else if (take_pkt) begin
            pend_q <= pend_q & ~cur_first;
        end
    end

    // Payload capture at event acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q      <= '0;
            nip_q      <= '0;
            base_q     <= '0;
            tgt_kind_q <= PK_TGT;
            tgt_av_q   <= 1'b0;
            nonroot_q  <= 1'b0;
        end else if (take_ev) begin
            tgt_q      <= ev_target;
            nip_q      <= ev_next_ip;
            base_q     <= ev_new_base;
            tgt_kind_q <= plan_tgt_kind;
            tgt_av_q   <= plan_tgt_av;
            nonroot_q  <= ev_guest_vis;
        end
    end

    // Output mux for the selected slot.
    always_comb begin
        pkt_kind     = PK_FLOW;
        pkt_addr     = '0;
        pkt_addr_vld = 1'b0;
        pkt_nonroot  = 1'b0;
        case (int'(cur_idx))
            SLOT_FLOW: begin
                pkt_kind     = PK_FLOW;
                pkt_addr     = nip_q;
                pkt_addr_vld = 1'b1;
            end
            SLOT_BASE: begin
                pkt_kind     = PK_BASE;
                pkt_addr     = base_q;
                pkt_addr_vld = 1'b1;
                pkt_nonroot  = nonroot_q;
            end
            SLOT_MODE: pkt_kind = PK_MODE;
            SLOT_TGT: begin
                pkt_kind     = tgt_kind_q;
                pkt_addr     = tgt_av_q ? tgt_q : '0;
                pkt_addr_vld = tgt_av_q;
            end
            SLOT_STOP: pkt_kind = PK_STOP;
            default: pkt_kind = PK_FLOW;
        endcase
    end

    // R1: events only accepted when nothing is pending.
    a_r1_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        take_ev |-> !pkt_valid);
    // R2: a stalled packet holds kind and payload.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_kind)
            && $stable(pkt_addr) && $stable(pkt_addr_vld) && $stable(pkt_nonroot)));
    // R3: each handover advances strictly in slot order.
    a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
        take_pkt |=> (!pkt_valid || (cur_idx > $past(cur_idx))));
    // R5: only the base packet may raise the non-root flag.
    a_r5_nonroot_base_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_kind != PK_BASE) |-> !pkt_nonroot);
    // R7: mode and stop packets never carry an address.
    a_r7_mode_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && (pkt_kind == PK_MODE || pkt_kind == PK_STOP)) |-> !pkt_addr_vld);
endmodule

// File: tb/test_trace_pkt_seq.sv
`timescale 1ns/1ps
module test_trace_pkt_seq;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 0, ev_is_intr = 0, ev_en_before = 0, ev_en_after = 0;
    logic ev_ctx_after = 0, ev_base_chg = 0, ev_priv_filt = 0, ev_guest_vis = 0;
    logic ev_in_stop = 0, ev_mode_chg = 0, sync_mark = 0, pkt_ready = 0;
    logic [AW-1:0] ev_target = '0, ev_next_ip = '0, ev_new_base = '0;
    logic ev_ready, pkt_valid, pkt_addr_vld, pkt_nonroot;
    logic [2:0] pkt_kind;
    logic [AW-1:0] pkt_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit ms = 0;   // bench model of "mode sent since sync"

    int          exp_n;
    logic [2:0]  ek [5];
    logic [AW-1:0] ea [5];
    bit          eav [5];
    bit          enr [5];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trace_pkt_seq #(.ADDR_W(AW)) i_trace_pkt_seq (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_is_intr(ev_is_intr), .ev_en_before(ev_en_before), .ev_en_after(ev_en_after),
        .ev_ctx_after(ev_ctx_after), .ev_base_chg(ev_base_chg), .ev_priv_filt(ev_priv_filt),
        .ev_guest_vis(ev_guest_vis), .ev_in_stop(ev_in_stop), .ev_mode_chg(ev_mode_chg),
        .ev_target(ev_target), .ev_next_ip(ev_next_ip), .ev_new_base(ev_new_base),
        .sync_mark(sync_mark), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_kind(pkt_kind), .pkt_addr(pkt_addr), .pkt_addr_vld(pkt_addr_vld),
        .pkt_nonroot(pkt_nonroot)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string kind_tag(input logic [2:0] k);
        case (k)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R7/R8";
            3'd6: return "R9";
            default: return "R6";
        endcase
    endfunction

    // Expected packet list computed from the requirements.
    task automatic build_expect(input bit intr, input bit eb, input bit ea_, input bit cx,
                                input bit bc, input bit pf, input bit gv, input bit st,
                                input bit mc, input bit sy);
        bit ms_eff;
        ms_eff = sy ? 1'b0 : ms;        // R8: sync before decision
        ms = ms_eff;
        exp_n = 0;
        if (intr && eb && !ea_) begin   // R4
            ek[exp_n] = 3'd0; ea[exp_n] = ev_next_ip; eav[exp_n] = 1; enr[exp_n] = 0; exp_n++;
        end
        if (cx && bc && pf) begin       // R5
            ek[exp_n] = 3'd1; ea[exp_n] = ev_new_base; eav[exp_n] = 1; enr[exp_n] = gv; exp_n++;
        end
        if (ea_ && (eb ? mc : (mc || !ms_eff))) begin   // R7
            ek[exp_n] = 3'd2; ea[exp_n] = '0; eav[exp_n] = 0; enr[exp_n] = 0; exp_n++;
            ms = 1;
        end
        if (eb || ea_) begin            // R6
            ek[exp_n] = (eb && ea_) ? 3'd3 : (ea_ ? 3'd4 : 3'd5);
            eav[exp_n] = ea_ || cx;
            ea[exp_n] = eav[exp_n] ? ev_target : '0;
            enr[exp_n] = 0; exp_n++;
        end
        if (!ea_ && cx && st) begin     // R9
            ek[exp_n] = 3'd6; ea[exp_n] = '0; eav[exp_n] = 0; enr[exp_n] = 0; exp_n++;
        end
    endtask

    task automatic run_event(input int id, input bit intr, input bit eb, input bit ea_,
                             input bit cx, input bit bc, input bit pf, input bit gv,
                             input bit st, input bit mc, input bit sy);
        int idx;
        bit stalled;
        @(negedge clk);
        ev_is_intr = intr; ev_en_before = eb; ev_en_after = ea_; ev_ctx_after = cx;
        ev_base_chg = bc; ev_priv_filt = pf; ev_guest_vis = gv; ev_in_stop = st;
        ev_mode_chg = mc; sync_mark = sy;
        ev_target = AW'(16'hA000 + id); ev_next_ip = AW'(16'h5000 + id);
        ev_new_base = AW'(16'hC000 + id);
        ev_valid = 1;
        pkt_ready = 0;
        chk(ev_ready == 1'b1, "R1", "ev_ready when idle", 32'(ev_ready), 1);
        build_expect(intr, eb, ea_, cx, bc, pf, gv, st, mc, sy);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 0; sync_mark = 0;
        idx = 0; stalled = 0;
        forever begin
            if (idx == exp_n) begin
                chk(pkt_valid == 1'b0, "R1", "no extra packet", 32'(pkt_valid), 0);
                chk(ev_ready == 1'b1, "R1", "ready after drain", 32'(ev_ready), 1);
                break;
            end
            if (!pkt_valid) begin
                chk(0, "R3", "missing packet", 32'(idx), 32'(exp_n));
                break;
            end
            chk(pkt_kind == ek[idx], stalled ? "R2" : "R3", "kind",
                32'(pkt_kind), 32'(ek[idx]));
            chk(pkt_addr == ea[idx], stalled ? "R2" : kind_tag(ek[idx]), "addr",
                32'(pkt_addr), 32'(ea[idx]));
            chk(pkt_addr_vld == eav[idx], kind_tag(ek[idx]), "addr_vld",
                32'(pkt_addr_vld), 32'(eav[idx]));
            chk(pkt_nonroot == enr[idx], "R5", "nonroot",
                32'(pkt_nonroot), 32'(enr[idx]));
            pkt_ready = ((cyc % 3) != 1);
            stalled = !pkt_ready;
            @(posedge clk);
            if (pkt_ready) idx++;
            @(negedge clk);
            pkt_ready = 0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R10: reset state.
        chk(pkt_valid == 1'b0, "R10", "pkt_valid after reset", 32'(pkt_valid), 0);
        chk(ev_ready == 1'b1, "R10", "ev_ready after reset", 32'(ev_ready), 1);
        // R10/R8: first enabling interrupt emits mode packet without mode change.
        run_event(1000, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        // R8: second one does not.
        run_event(1001, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        // R8: after a same-cycle sync it does again.
        run_event(1002, 1, 0, 1, 1, 0, 0, 0, 0, 0, 1);
        // R1: no-packet interrupt (0,0,0).
        run_event(1003, 1, 0, 0, 0, 1, 1, 1, 1, 1, 0);
        // Full sweep over operation, enables and flags.
        for (int e = 0; e < 512; e++) begin
            run_event(e, e[8], e[7], e[6], e[5], e[4], e[3], e[2], e[1], e[0],
                      (e % 7) == 3);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule